// File: doc/BRIEF.md
# Mode-Aware Serial Baud Tick Generator

This block makes the clock-enable ticks for a serial engine that can run as a UART, an SPI port or an I2C port. A reference pulse stream comes from one of two sources: an internal enable or an external enable. The stream drives a reloading down-counter. Each time the counter underflows it makes a base tick. A shared prescaler counts these base ticks, and from it the block derives a divide-by-2 tap and a divide-by-16 tap.

A three-bit operating-mode field decides which tap reaches the transmitter and which reaches the receiver. No other setting is needed for this choice.

Software reaches a small register file through a simple write and read port. The file holds three registers:
- a control register with an enable bit, a self-clearing software-reset bit and the mode field;
- a 16-bit baud reload value;
- a debug scratch register that keeps its value through a software reset.

Top module: `baud_tick_gen`

## Requirements
- R1: After the asynchronous reset, the control, baud and debug registers read back 0, and `txTick` and `rxTick` are low.
- R2: When running in a UART mode (mode 0 or 1), `rxTick` pulses for one cycle on the 1st selected reference pulse after enabling, and then on every (BAUD+1)th selected pulse after that. Each tick appears in the cycle after the reference pulse that produced it.
- R3: In a UART mode, `txTick` pulses on the 16th, 32nd, … base tick after enabling, and always together with `rxTick`.
- R4: In the synchronous modes 2 to 5, `txTick` and `rxTick` both pulse on the 2nd, 4th, 6th, … base tick after enabling.
- R5: Mode 0 counts only `refExt` pulses. Every other mode counts only `refInt` pulses. The unselected reference input has no effect on the ticks.
- R6: While the enable bit is 0, no ticks are produced and the counter and prescaler are held at zero. After enabling again, the first selected reference pulse produces a tick.
- R7: The reserved mode codes 6 and 7 produce no ticks, even while the block is enabled.
- R8: A write to the control register made while the enable bit is 1 leaves the mode field unchanged. The enable bit itself is still written.
- R9: Writing 1 to bit 1 of the control register starts a software reset:
  - bit 1 reads back as 1 for two cycles;
  - in the second of those cycles, the enable bit, the mode field and the baud register read back 0;
  - the debug register keeps its value;
  - bit 1 then returns to 0.
- R10: All register writes issued while the software reset is in progress are ignored.
- R11: Register map, addressed by `wrAddr`/`rdAddr`:
  - address 0 is the control register, with bit 0 enable, bit 1 software reset and bits 4:2 mode;
  - address 1 is the baud register;
  - address 2 is the debug register;
  - address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial engine clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refInt | input | 1 | Internal reference pulse enable |
| refExt | input | 1 | External reference pulse enable |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| txTick | output | 1 | Transmitter clock-enable tick |
| rxTick | output | 1 | Receiver clock-enable tick |

## Verification
The hardest case to reach from the ports is the last cycle of the software-reset window. The registers are already cleared, but the reset bit still reads 1 and writes must still be refused. The stimulus issues the reset, reads the control register twice in a row, and then drives a baud write by hand so that it lands exactly in that final cycle. A second difficult case is checking that the mode field stays unchanged when it is written while the block is enabled. The bench writes a synchronous mode code during an asynchronous run. It then confirms both the readback and the continuing divide-by-16 tick spacing against a reference-pulse model.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  parameter int BAUD_W = 16;
  parameter int ADDR_W = 2;
  parameter int MODE_W = 3;
  parameter int PRE_W  = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_BAUD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DBG  = 2'd2;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SWRST_BIT = 1;
  localparam int CTRL_MODE_LSB = 2;

  typedef enum logic [1:0] {TAP_NONE, TAP_ASYNC, TAP_SYNC} tapSel_e;

  typedef enum logic [1:0] {SW_IDLE, SW_CLEAR, SW_DONE} swState_e;

  typedef struct packed {
    logic              run;
    logic              useExt;
    tapSel_e           tap;
    logic [BAUD_W-1:0] baud;
  } genCfg_t;
endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baudgen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BAUD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BAUD_W-1:0] rdData,
  output genCfg_t           cfg
);
  logic              enableQ;
  logic [MODE_W-1:0] modeQ;
  logic [BAUD_W-1:0] baudQ;
  logic [BAUD_W-1:0] dbgQ;
  swState_e          swState;
  logic              busy;
  tapSel_e           tapSel;
  logic              useExt;

  assign busy = (swState != SW_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      modeQ   <= '0;
      baudQ   <= '0;
      dbgQ    <= '0;
      swState <= SW_IDLE;
    end else begin
      case (swState)
        SW_IDLE: begin
          if (wrEn) begin
            case (wrAddr)
              ADDR_CTRL: begin
                if (wrData[CTRL_SWRST_BIT]) begin
                  swState <= SW_CLEAR;
                end else begin
                  enableQ <= wrData[CTRL_EN_BIT];
                  if (!enableQ) modeQ <= wrData[CTRL_MODE_LSB +: MODE_W];
                end
              end
              ADDR_BAUD: baudQ <= wrData;
              ADDR_DBG:  dbgQ  <= wrData;
              default: ;
            endcase
          end
        end
        SW_CLEAR: begin
          enableQ <= 1'b0;
          modeQ   <= '0;
          baudQ   <= '0;
          swState <= SW_DONE;
        end
        default: swState <= SW_IDLE;
      endcase
    end
  end

  always_comb begin
    useExt = 1'b0;
    case (modeQ)
      3'd0:                   begin tapSel = TAP_ASYNC; useExt = 1'b1; end
      3'd1:                   tapSel = TAP_ASYNC;
      3'd2, 3'd3, 3'd4, 3'd5: tapSel = TAP_SYNC;
      default:                tapSel = TAP_NONE;
    endcase
  end

  always_comb begin
    cfg.run    = enableQ && !busy && (tapSel != TAP_NONE);
    cfg.useExt = useExt;
    cfg.tap    = tapSel;
    cfg.baud   = baudQ;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL: begin
        rdData[CTRL_EN_BIT]                   = enableQ;
        rdData[CTRL_SWRST_BIT]                = busy;
        rdData[CTRL_MODE_LSB +: MODE_W]       = modeQ;
      end
      ADDR_BAUD: rdData = baudQ;
      ADDR_DBG:  rdData = dbgQ;
      default:   rdData = '0;
    endcase
  end

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && !busy) |=> $stable(modeQ));

  // R9
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swState == SW_CLEAR) |=> (!enableQ && modeQ == '0 && baudQ == '0 && swState == SW_DONE));

  // R10
  busy_dbg_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(dbgQ));

  // R9
  swrst_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swState == SW_DONE) |=> !busy);
endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baudgen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refInt,
  input  logic    refExt,
  input  genCfg_t cfg,
  output logic    txTick,
  output logic    rxTick
);
  logic [BAUD_W-1:0] cnt;
  logic [PRE_W-1:0]  pre;
  logic              refSel;
  logic              fireBase;
  logic              txPick;
  logic              rxPick;

  assign refSel   = cfg.useExt ? refExt : refInt;
  assign fireBase = cfg.run && refSel && (cnt == '0);

  always_comb begin
    case (cfg.tap)
      TAP_ASYNC: begin txPick = &pre;  rxPick = 1'b1;   end
      TAP_SYNC:  begin txPick = pre[0]; rxPick = pre[0]; end
      default:   begin txPick = 1'b0;  rxPick = 1'b0;   end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      pre    <= '0;
      txTick <= 1'b0;
      rxTick <= 1'b0;
    end else if (!cfg.run) begin
      cnt    <= '0;
      pre    <= '0;
      txTick <= 1'b0;
      rxTick <= 1'b0;
    end else begin
      txTick <= fireBase && txPick;
      rxTick <= fireBase && rxPick;
      if (refSel) begin
        if (cnt == '0) begin
          cnt <= cfg.baud;
          pre <= pre + 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.run |=> (!txTick && !rxTick && cnt == '0 && pre == '0));

  // R7
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.tap == TAP_NONE) |=> (!txTick && !rxTick));

  // R3
  tx_with_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    txTick |-> rxTick);

  // R2
  count_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.run && cnt != '0) |=> !rxTick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baudgen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              refInt,
  input  logic              refExt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BAUD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BAUD_W-1:0] rdData,
  output logic              txTick,
  output logic              rxTick
);
  genCfg_t cfg;

  baud_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .cfg    (cfg)
  );

  baud_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .refInt (refInt),
    .refExt (refExt),
    .cfg    (cfg),
    .txTick (txTick),
    .rxTick (rxTick)
  );
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refInt = 1'b0;
  logic        refExt = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        txTick;
  logic        rxTick;

  int checks = 0;
  int fails  = 0;
  int kRef   = 0;
  int baseN  = 0;

  typedef struct {
    bit    tx;
    bit    rx;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  baud_tick_gen u0 (
    .clk(clk), .rstN(rstN), .refInt(refInt), .refExt(refExt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .txTick(txTick), .rxTick(rxTick)
  );

  always #4 clk = ~clk;

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  // monitor: pops one expectation per cycle just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (txTick !== it.tx || rxTick !== it.rx) begin
          fails++;
          $display("FAIL %s: actual tx=%0b rx=%0b expected tx=%0b rx=%0b",
                   it.tag, txTick, rxTick, it.tx, it.rx);
        end
      end
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkReg(input logic [1:0] a, input logic [15:0] exp, input string tag);
    rdAddr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: reg %0d actual=%h expected=%h", tag, a, rdData, exp);
    end
  endtask

  task automatic modelRestart();
    kRef = 0;
    baseN = 0;
  endtask

  // kind: 0 no ticks expected, 1 asynchronous taps, 2 synchronous taps
  task automatic runPhase(input int cycles, input int gap, input int baud,
                          input bit useExt, input int kind, input string tag);
    for (int c = 0; c < cycles; c++) begin
      bit sel;
      expItem_t it;
      sel = ((c % gap) == 0);
      @(negedge clk);
      if (useExt) begin refExt = sel; refInt = 1'b1; end
      else        begin refInt = sel; refExt = 1'b1; end
      it.tx = 1'b0; it.rx = 1'b0; it.tag = tag;
      if (kind != 0 && sel) begin
        if ((kRef % (baud + 1)) == 0) begin
          baseN++;
          if (kind == 1) begin
            it.rx = 1'b1;
            it.tx = ((baseN % 16) == 0);
          end else begin
            it.rx = ((baseN % 2) == 0);
            it.tx = ((baseN % 2) == 0);
          end
        end
        kRef++;
      end
      expQ.push_back(it);
    end
    @(negedge clk);
    refInt = 1'b0; refExt = 1'b0;
    @(negedge clk);
  endtask

  task automatic startMode(input int mode, input int baud);
    writeReg(2'd0, 16'h0000);
    writeReg(2'd1, 16'(baud));
    writeReg(2'd0, 16'((mode << 2) | 1));
    modelRestart();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state; R11 address 3 reads zero
    checkReg(2'd0, 16'h0000, "R1 ctrl");
    checkReg(2'd1, 16'h0000, "R1 baud");
    checkReg(2'd2, 16'h0000, "R1 dbg");
    checkReg(2'd3, 16'h0000, "R11 unused addr");
    checks++;
    if (txTick !== 1'b0 || rxTick !== 1'b0) begin
      fails++;
      $display("FAIL R1 ticks: actual tx=%0b rx=%0b expected 0 0", txTick, rxTick);
    end

    // R2 R3: internal UART, baud 2, dense reference
    startMode(1, 2);
    checkReg(2'd0, 16'h0005, "R11 ctrl layout");
    runPhase(120, 1, 2, 1'b0, 1, "R2/R3 mode1 baud2");

    // R8: mode write while enabled is ignored, run continues asynchronously
    writeReg(2'd0, 16'h0015);
    checkReg(2'd0, 16'h0005, "R8 mode held");
    runPhase(60, 1, 2, 1'b0, 1, "R8 async continues");

    // R5: external reference in mode 0, internal held high
    startMode(0, 0);
    runPhase(80, 2, 0, 1'b1, 1, "R5 external ref R3");

    // R4: SPI master, baud 1
    startMode(3, 1);
    runPhase(40, 1, 1, 1'b0, 2, "R4 mode3 baud1");

    // R4 R5: I2C slave, sparse internal reference
    startMode(4, 0);
    runPhase(40, 3, 0, 1'b0, 2, "R4 mode4 gap3");

    // R7: reserved codes
    startMode(6, 0);
    runPhase(20, 1, 0, 1'b0, 0, "R7 mode6");
    startMode(7, 0);
    runPhase(20, 1, 0, 1'b0, 0, "R7 mode7");

    // R6: disable then re-enable restarts the counter
    startMode(5, 3);
    runPhase(18, 1, 3, 1'b0, 2, "R6 pre-disable");
    writeReg(2'd0, 16'h0014);
    runPhase(20, 1, 3, 1'b0, 0, "R6 disabled");
    writeReg(2'd0, 16'h0015);
    modelRestart();
    runPhase(30, 1, 3, 1'b0, 2, "R6 re-enabled");

    // R9 R10: software reset keeps debug, refuses writes while busy
    writeReg(2'd2, 16'hA5A5);
    startMode(1, 7);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'h0002;
    @(negedge clk);
    wrEn = 1'b0;
    checkReg(2'd0, 16'h0007, "R9 busy first cycle");
    @(negedge clk);
    checkReg(2'd0, 16'h0002, "R9 cleared busy");
    checkReg(2'd1, 16'h0000, "R9 baud cleared");
    checkReg(2'd2, 16'hA5A5, "R9 dbg kept");
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 16'h0005;
    @(negedge clk);
    wrEn = 1'b0;
    checkReg(2'd0, 16'h0000, "R9 busy released");
    checkReg(2'd1, 16'h0000, "R10 write in busy ignored");
    modelRestart();
    runPhase(20, 1, 0, 1'b0, 0, "R9 no ticks after reset");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule